// File: doc/BRIEF.md
# Priority Interrupt Sorter

This block takes a snapshot of every interrupt line in one to three banks of 32 lines and picks the single line that should be served next for one interrupt class. Each line is described by four things: a pending bit, a mask bit, a class bit and a small priority number. The caller selects which class is sorted, normal (class bit 0) or fast (class bit 1), and pulses `start`. The block then reports the winning line as a code together with a flag that says whether any line qualified at all.

Two build variants share one interface, chosen by a parameter. The tree variant compares all lines at once in a balanced tree of pairwise comparators, and answers on the clock after `start`. The scan variant sweeps the lines in fixed-size chunks, one chunk per clock. It reuses a small tree of chunk width and keeps a running best, trading latency for logic. In both variants the result is held in output registers. The result changes only on the cycle `done` is high.

Top module: `prio_sorter`

## Requirements
- R1: Line i is a candidate only when `pend[i]`=1, `mask[i]`=0 and `cls[i]` equals `fiq_sel`. A line of the other class never wins.
- R2: Among candidates the one with the numerically smallest priority wins; priority 0 is the most urgent. Line i's priority is `prio[i*PRIO_W +: PRIO_W]`.
- R3: When several candidates share the smallest priority, the one with the larger global index wins.
- R4: Global line index i is bank i/32, line i%32. The reported code is 32 times the bank plus the line, so for example bank 2 line 5 gives 69.
- R5: When there is no candidate, `code` is 0.
- R6: `valid` is 1 exactly when at least one candidate exists, so a real winner at line 0 reports valid=1, code=0.
- R7: `done` is a one-cycle pulse. It comes 1 cycle after `start` in the tree variant, and NUM_BANKS*32/SCAN_STEP+1 cycles after `start` in the scan variant.
- R8: `code` and `valid` keep their values on every cycle where `done` is low.
- R9: In the scan variant a `start` during a running scan is ignored: no extra `done` is produced and the first scan finishes on time.
- R10: After reset, `code`=0, `valid`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one sort of the current inputs |
| fiq_sel | input | 1 | Class being sorted: 1 fast, 0 normal |
| pend | input | NUM_BANKS*32 | Pending bit per line |
| mask | input | NUM_BANKS*32 | Mask bit per line, 1 blocks the line |
| cls | input | NUM_BANKS*32 | Class bit per line |
| prio | input | NUM_BANKS*32*PRIO_W | Priority per line, packed by line index |
| done | output | 1 | One-cycle pulse when a new result is loaded |
| valid | output | 1 | A candidate existed in the finished sort |
| code | output | $clog2(NUM_BANKS*32) | Winning line code, 0 when none |

## Verification
The embedded assertions check on every cycle that a reported winner is a candidate, that its priority matches that line's priority field, and that `valid` agrees with whether any candidate exists. They also check that an empty result carries code 0, that outputs move only with `done`, and that a running scan neither stops early nor pulses `done` twice. Two things only the bench's scenarios can show: that the winner really is the minimum priority with ties resolved toward the higher index, and that the latencies come out as the requirements state. The bench shows them by comparing both variants against its own model, over directed corner cases and seeded random line sets with deliberately frequent priority ties.

// File: rtl/prio_sorter_pkg.sv
package prio_sorter_pkg;

  localparam int LINES_PER_BANK = 32;
  localparam int PRIO_MAX_W     = 8;

  // Decide whether the higher-indexed contender replaces the lower-indexed
  // one. Smaller priority wins; equal priority favours the higher index.
  function automatic logic hi_wins(input logic                  lo_v,
                                   input logic [PRIO_MAX_W-1:0] lo_p,
                                   input logic                  hi_v,
                                   input logic [PRIO_MAX_W-1:0] hi_p);
    return hi_v && (!lo_v || (hi_p <= lo_p));
  endfunction

  // Qualification of one line for the class under sort.
  function automatic logic line_qualifies(input logic pend_b,
                                          input logic mask_b,
                                          input logic cls_b,
                                          input logic want_fast);
    return pend_b && !mask_b && (cls_b == want_fast);
  endfunction

endpackage

// File: rtl/prio_cand.sv
module prio_cand
  import prio_sorter_pkg::*;
#(
  parameter int NLINES = 96
) (
  input  logic [NLINES-1:0] pend,
  input  logic [NLINES-1:0] mask,
  input  logic [NLINES-1:0] cls,
  input  logic              fiq_sel,
  output logic [NLINES-1:0] cand,
  output logic              any_cand
);

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    assign cand[g] = line_qualifies(pend[g], mask[g], cls[g], fiq_sel);
  end

  assign any_cand = |cand;

endmodule

// File: rtl/prio_reduce.sv
module prio_reduce
  import prio_sorter_pkg::*;
#(
  parameter int N      = 96,
  parameter int PRIO_W = 6,
  parameter int IDX_W  = 7
) (
  input  logic [N-1:0]        cand,
  input  logic [N*PRIO_W-1:0] prio,
  output logic                win_v,
  output logic [PRIO_W-1:0]   win_p,
  output logic [IDX_W-1:0]    win_i
);

  localparam int LVLS   = (N > 1) ? $clog2(N) : 0;
  localparam int NP     = 1 << LVLS;
  localparam int NNODES = 2 * NP - 1;

  // Heap-numbered nodes: leaves occupy NP-1 .. 2*NP-2 in index order,
  // so the left child always holds the lower line indices.
  logic              nv [NNODES];
  logic [PRIO_W-1:0] np [NNODES];
  logic [IDX_W-1:0]  ni [NNODES];

  for (genvar l = 0; l < NP; l++) begin : g_leaf
    if (l < N) begin : g_real
      assign nv[NP-1+l] = cand[l];
      assign np[NP-1+l] = prio[l*PRIO_W +: PRIO_W];
      assign ni[NP-1+l] = IDX_W'(l);
    end else begin : g_pad
      assign nv[NP-1+l] = 1'b0;
      assign np[NP-1+l] = '0;
      assign ni[NP-1+l] = '0;
    end
  end

  for (genvar k = 0; k < NP - 1; k++) begin : g_node
    logic take_hi;
    assign take_hi = hi_wins(nv[2*k+1], PRIO_MAX_W'(np[2*k+1]),
                             nv[2*k+2], PRIO_MAX_W'(np[2*k+2]));
    assign nv[k] = nv[2*k+1] | nv[2*k+2];
    assign np[k] = take_hi ? np[2*k+2] : np[2*k+1];
    assign ni[k] = take_hi ? ni[2*k+2] : ni[2*k+1];
  end

  assign win_v = nv[0];
  assign win_p = np[0];
  assign win_i = ni[0];

endmodule

// File: rtl/prio_scan.sv
module prio_scan
  import prio_sorter_pkg::*;
#(
  parameter int NLINES = 96,
  parameter int PRIO_W = 6,
  parameter int STEP   = 8,
  parameter int IDX_W  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [NLINES-1:0]        cand,
  input  logic [NLINES*PRIO_W-1:0] prio,
  output logic                     finish,
  output logic                     res_v,
  output logic [PRIO_W-1:0]        res_p,
  output logic [IDX_W-1:0]         res_i
);

  localparam int NCHUNK = NLINES / STEP;
  localparam int CW     = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
  localparam int LW     = (STEP > 1) ? $clog2(STEP) : 1;
  localparam logic [CW-1:0] LAST = CW'(NCHUNK - 1);

  logic              busy;
  logic [CW-1:0]     chunk;
  logic              acc_v;
  logic [PRIO_W-1:0] acc_p;
  logic [IDX_W-1:0]  acc_i;

  logic [STEP-1:0]        sl_cand;
  logic [STEP*PRIO_W-1:0] sl_prio;
  logic                   ch_v;
  logic [PRIO_W-1:0]      ch_p;
  logic [LW-1:0]          ch_i;
  logic [IDX_W-1:0]       ch_gi;
  logic                   take_chunk;

  always_comb begin
    int base;
    base    = int'(chunk) * STEP;
    sl_cand = cand[base +: STEP];
    sl_prio = prio[base*PRIO_W +: STEP*PRIO_W];
    ch_gi   = IDX_W'(base) + IDX_W'(ch_i);
  end

  prio_reduce #(
    .N      (STEP),
    .PRIO_W (PRIO_W),
    .IDX_W  (LW)
  ) u_chunk_tree (
    .cand  (sl_cand),
    .prio  (sl_prio),
    .win_v (ch_v),
    .win_p (ch_p),
    .win_i (ch_i)
  );

  // The chunk always holds higher indices than the running best.
  assign take_chunk = hi_wins(acc_v, PRIO_MAX_W'(acc_p), ch_v, PRIO_MAX_W'(ch_p));
  assign finish     = busy && (chunk == LAST);
  assign res_v      = acc_v | ch_v;
  assign res_p      = take_chunk ? ch_p  : acc_p;
  assign res_i      = take_chunk ? ch_gi : acc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      chunk <= '0;
      acc_v <= 1'b0;
      acc_p <= '0;
      acc_i <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        chunk <= '0;
        acc_v <= 1'b0;
        acc_p <= '0;
        acc_i <= '0;
      end
    end else begin
      acc_v <= res_v;
      acc_p <= res_p;
      acc_i <= res_i;
      if (finish) begin
        busy  <= 1'b0;
        chunk <= '0;
      end else begin
        chunk <= chunk + 1'b1;
      end
    end
  end

  // R7
  finish_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !finish);

  // R9
  scan_runs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> (busy && chunk == $past(chunk) + 1'b1));

  // R7
  chunk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (chunk <= LAST));

endmodule

// File: rtl/prio_sorter.sv
module prio_sorter
  import prio_sorter_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int PRIO_W    = 6,
  parameter bit USE_SCAN  = 1'b1,
  parameter int SCAN_STEP = 8,
  localparam int NLINES   = NUM_BANKS * LINES_PER_BANK,
  localparam int CODE_W   = $clog2(NLINES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     fiq_sel,
  input  logic [NLINES-1:0]        pend,
  input  logic [NLINES-1:0]        mask,
  input  logic [NLINES-1:0]        cls,
  input  logic [NLINES*PRIO_W-1:0] prio,
  output logic                     done,
  output logic                     valid,
  output logic [CODE_W-1:0]        code
);

  logic [NLINES-1:0] cand;
  logic              any_cand;
  logic              res_load;
  logic              res_v;
  logic [PRIO_W-1:0] res_p;
  logic [CODE_W-1:0] res_i;

  prio_cand #(.NLINES(NLINES)) u_cand (
    .pend     (pend),
    .mask     (mask),
    .cls      (cls),
    .fiq_sel  (fiq_sel),
    .cand     (cand),
    .any_cand (any_cand)
  );

  if (USE_SCAN) begin : g_scan
    prio_scan #(
      .NLINES (NLINES),
      .PRIO_W (PRIO_W),
      .STEP   (SCAN_STEP),
      .IDX_W  (CODE_W)
    ) u_scan (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .cand   (cand),
      .prio   (prio),
      .finish (res_load),
      .res_v  (res_v),
      .res_p  (res_p),
      .res_i  (res_i)
    );
  end else begin : g_tree
    prio_reduce #(
      .N      (NLINES),
      .PRIO_W (PRIO_W),
      .IDX_W  (CODE_W)
    ) u_tree (
      .cand  (cand),
      .prio  (prio),
      .win_v (res_v),
      .win_p (res_p),
      .win_i (res_i)
    );
    assign res_load = start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      valid <= 1'b0;
      code  <= '0;
    end else begin
      done <= res_load;
      if (res_load) begin
        valid <= res_v;
        code  <= res_v ? res_i : '0;
      end
    end
  end

  // R1
  winner_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && valid) |-> cand[code]);

  // R2
  winner_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_load && res_v) |-> (res_p == prio[int'(res_i)*PRIO_W +: PRIO_W]));

  // R5
  empty_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (code == '0));

  // R6
  valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (valid == any_cand));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(code) && $stable(valid)));

endmodule

// File: tb/tb_prio_sorter.sv
module tb_prio_sorter;

  localparam int NB     = 3;
  localparam int PW     = 6;
  localparam int NL     = NB * 32;
  localparam int CW     = $clog2(NL);
  localparam int STEP   = 8;
  localparam int SCAN_L = NL / STEP + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              fiq_sel = 1'b0;
  logic [NL-1:0]     pend = '0;
  logic [NL-1:0]     mask = '1;
  logic [NL-1:0]     cls = '0;
  logic [NL*PW-1:0]  prio = '0;

  logic              s_done, s_valid, t_done, t_valid;
  logic [CW-1:0]     s_code, t_code;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  prio_sorter #(.NUM_BANKS(NB), .PRIO_W(PW), .USE_SCAN(1'b1), .SCAN_STEP(STEP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fiq_sel(fiq_sel),
    .pend(pend), .mask(mask), .cls(cls), .prio(prio),
    .done(s_done), .valid(s_valid), .code(s_code));

  prio_sorter #(.NUM_BANKS(NB), .PRIO_W(PW), .USE_SCAN(1'b0), .SCAN_STEP(STEP)) dut_t (
    .clk(clk), .rst_n(rst_n), .start(start), .fiq_sel(fiq_sel),
    .pend(pend), .mask(mask), .cls(cls), .prio(prio),
    .done(t_done), .valid(t_valid), .code(t_code));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Model: sweep from the top index down, replace only on strictly smaller
  // priority, so the highest index among the minimum survives.
  function automatic void model(output bit ev, output int ec);
    int best;
    ev = 1'b0; ec = 0; best = 0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (pend[i] && !mask[i] && (cls[i] == fiq_sel)) begin
        if (!ev || int'(prio[i*PW +: PW]) < best) begin
          ev = 1'b1; ec = i; best = int'(prio[i*PW +: PW]);
        end
      end
    end
  endfunction

  task automatic set_prio(input int line, input int p);
    prio[line*PW +: PW] = PW'(p);
  endtask

  task automatic run_case(input string req, input int restart_at, input int t_pulses);
    bit ev; int ec;
    int s_lat, t_lat, s_cnt, t_cnt;
    int s_c, t_c, s_v, t_v;
    model(ev, ec);
    s_lat = -1; t_lat = -1; s_cnt = 0; t_cnt = 0;
    s_c = 0; t_c = 0; s_v = 0; t_v = 0;
    @(negedge clk);
    start = 1'b1;
    for (int cyc = 1; cyc <= 40; cyc++) begin
      @(negedge clk);
      start = (cyc == restart_at);
      if (s_done) begin
        s_cnt++;
        if (s_lat < 0) begin s_lat = cyc; s_c = int'(s_code); s_v = int'(s_valid); end
      end
      if (t_done) begin
        t_cnt++;
        if (t_lat < 0) begin t_lat = cyc; t_c = int'(t_code); t_v = int'(t_valid); end
      end
    end
    chk(s_lat == SCAN_L, {req, " R7 scan latency"}, s_lat, SCAN_L);
    chk(t_lat == 1, {req, " R7 tree latency"}, t_lat, 1);
    chk(s_cnt == 1, {req, " R7/R9 scan done pulses"}, s_cnt, 1);
    chk(t_cnt == t_pulses, {req, " R7 tree done pulses"}, t_cnt, t_pulses);
    chk(s_v == int'(ev), {req, " scan valid"}, s_v, int'(ev));
    chk(t_v == int'(ev), {req, " tree valid"}, t_v, int'(ev));
    chk(s_c == ec, {req, " scan code"}, s_c, ec);
    chk(t_c == ec, {req, " tree code"}, t_c, ec);
    // R8: outputs still hold the result well after done
    chk(int'(s_code) == ec && s_valid == ev, {req, " R8 scan hold"}, int'(s_code), ec);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    // R10: reset values
    chk(s_done == 0 && t_done == 0, "R10 done", int'(s_done), 0);
    chk(s_valid == 0 && t_valid == 0, "R10 valid", int'(s_valid), 0);
    chk(s_code == 0 && t_code == 0, "R10 code", int'(s_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_code == 0 && s_valid == 0 && s_done == 0, "R10 after release", int'(s_code), 0);

    // R5 R6: everything pending but masked
    pend = '1; mask = '1; cls = '0; fiq_sel = 0;
    run_case("R5 all masked", 0, 1);

    // R6: only line 0 qualifies
    pend = '0; mask = '1; pend[0] = 1; mask[0] = 0; set_prio(0, 7);
    run_case("R6 line zero", 0, 1);

    // R3: all lines equal priority, normal class
    pend = '1; mask = '0; cls = '0; prio = '0;
    for (int i = 0; i < NL; i++) set_prio(i, 9);
    run_case("R3 all tie", 0, 1);

    // R1: fast class requested while every line is normal class
    fiq_sel = 1;
    run_case("R1 wrong class", 0, 1);

    // R1: fast class with mixed classes; fast lines have the worse priority
    for (int i = 0; i < NL; i++) begin cls[i] = (i % 3 == 0); set_prio(i, cls[i] ? 20 : 1); end
    run_case("R1 class filter", 0, 1);

    // R2: smallest priority wins regardless of index
    fiq_sel = 0; cls = '0;
    for (int i = 0; i < NL; i++) set_prio(i, 5);
    set_prio(70, 1); set_prio(10, 0);
    run_case("R2 minimum", 0, 1);

    // R4: single fast line at bank 2 line 5 -> code 69
    pend = '0; mask = '1; cls = '0; fiq_sel = 1;
    pend[69] = 1; mask[69] = 0; cls[69] = 1; set_prio(69, 33);
    run_case("R4 bank2 line5", 0, 1);

    // R3: tie inside bank 0 beats a worse line in bank 1
    pend = '0; mask = '0; cls = '0; fiq_sel = 0;
    pend[3] = 1; pend[31] = 1; pend[40] = 1;
    set_prio(3, 2); set_prio(31, 2); set_prio(40, 3);
    run_case("R3 tie in bank", 0, 1);

    // R9: a second start during the scan is ignored (tree answers twice)
    pend = {$urandom, $urandom, $urandom};
    mask = {$urandom, $urandom, $urandom};
    for (int i = 0; i < NL; i++) set_prio(i, $urandom_range(0, 3));
    run_case("R9 restart ignored", 4, 2);

    // Random mix; narrow priority range makes ties common (R2 R3 R4)
    for (int n = 0; n < 40; n++) begin
      pend = {$urandom, $urandom, $urandom};
      mask = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      cls = {$urandom, $urandom, $urandom};
      fiq_sel = n[0];
      for (int i = 0; i < NL; i++) set_prio(i, $urandom_range(0, (n % 4) + 1));
      run_case("R2 R3 random", 0, 1);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule